// File: doc/BRIEF.md
# Quad-SPI pseudo-static RAM burst read controller

This block reads bursts of 32-bit words from a serial pseudo-static RAM over four bidirectional data lines. A single requester presents a word address and a word count. The controller opens a transaction by pulling chip select low. It shifts out the quad fast-read opcode and a 24-bit byte address, one nibble per memory clock. It then lets a fixed number of latency clocks pass with the data lines released. After that it samples read nibbles and packs them into words, which it hands to a local write port together with the word's index inside the request.

The memory is organised in pages of `2**PAGE_W` words. A burst that would run past the end of its page is cut into two transactions. The first ends at the page boundary. The second begins at the start of the next page, and the write index simply carries on across the two. Before any transaction starts, chip select must have been high for at least `GAP_CYC` system clocks, and the memory clock stays low for as long as chip select is high. A single `done_o` pulse reports that the whole request has finished.

Top module: `qspi_burst_reader`

## Requirements
- R1: Each transaction sends 8 header nibbles on `io_o` with `io_oe_o` high: the opcode 0xEB, then the 24-bit byte address `{req_addr, 2'b00}`. Both go most significant nibble first, and `io_o[3]` carries the most significant bit of each nibble.
- R2: A memory clock pulse lasts two system clocks: one low, one high. Outgoing nibbles change only while `sclk_o` is low. A read nibble is taken from `io_i` in the system cycle where `sclk_o` falls.
- R3: `io_oe_o` drops at the falling edge of the 8th pulse and stays low for the rest of the transaction. This covers the `WAIT_CLK` latency pulses that come before the first data nibble.
- R4: A transaction of n words has exactly 8 + `WAIT_CLK` + 8·n clock pulses while chip select is low.
- R5: Nibbles are packed high nibble first into bytes. Byte k of a word sits at bits [8k+7:8k]. `wr_en_o` is high for one cycle per word. `wr_idx_o` counts from 0 across the whole request, so word i holds memory word `req_addr + i`.
- R6: Let off be `req_addr mod 2**PAGE_W`. If `req_len` is greater than `2**PAGE_W − off`, the request runs as two transactions, and the first carries exactly `2**PAGE_W − off` words. Otherwise it runs as a single transaction.
- R7: The second transaction starts at the next page start and carries the remaining words. `done_o` pulses for one cycle only after the last transaction of the request.
- R8: Between any two transactions, chip select stays high for at least `GAP_CYC` system clocks.
- R9: `sclk_o` is low in every cycle where `cs_n_o` is high.
- R10: `req_valid_i` has no effect while a request is in progress. A request with `req_len_i` = 0 is ignored: it starts no transaction and gives no `done_o`.
- R11: Out of reset, `cs_n_o` is high and `sclk_o`, `io_oe_o`, `done_o` and `wr_en_o` are all low.

`req_len_i` must not exceed `2**PAGE_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_addr_i | input | WA_W | Start word address |
| req_len_i | input | LEN_W | Word count |
| done_o | output | 1 | One-cycle pulse when the request has finished |
| wr_en_o | output | 1 | Word-valid strobe for the local write port |
| wr_idx_o | output | LEN_W | Word index within the request |
| wr_data_o | output | 32 | Assembled little-endian word |
| cs_n_o | output | 1 | Memory chip select, active low |
| sclk_o | output | 1 | Memory clock |
| io_o | output | 4 | Outgoing nibble |
| io_oe_o | output | 1 | Output enable for io_o |
| io_i | input | 4 | Incoming nibble |

## Verification
The bench sweeps every start offset in a 16-word page. For each offset it uses lengths of one word, exactly the room left in the page, one word more than that room, and a full page. This exercises the off-by-one cases of the split. A controller with a wrong boundary compare would emit one transaction too many or too few, or put the second transaction at the wrong address. A wrong nibble or byte order would corrupt every word, and a miscounted latency or pulse total would shift the data by a nibble. The bench also measures the smallest chip-select-high gap and watches for the clock being high while the device is deselected, which catches a gap counter that is too short or a clock that keeps running. Last, it fires a request while the controller is busy and another with zero length, and confirms that neither one reaches the memory pins.

// File: rtl/qbr_pkg.sv
package qbr_pkg;
  localparam logic [7:0] QREAD_OP = 8'hEB;
  localparam int HDR_NIB = 8;
  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_GAP} qbr_st_e;
endpackage

// File: rtl/qbr_split.sv
module qbr_split #(
  parameter int WA_W   = 22,
  parameter int LEN_W  = 11,
  parameter int PAGE_W = 10,
  localparam int CW    = (LEN_W > PAGE_W ? LEN_W : PAGE_W) + 1
) (
  input  logic [WA_W-1:0]  addr_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             split_o,
  output logic [CW-1:0]    len1_o,
  output logic [CW-1:0]    len2_o,
  output logic [WA_W-1:0]  addr2_o
);
  logic [CW-1:0] room, len_w;

  always_comb begin
    room    = CW'(1 << PAGE_W) - CW'(addr_i[PAGE_W-1:0]);
    len_w   = CW'(len_i);
    split_o = len_w > room;
    len1_o  = split_o ? room : len_w;
    len2_o  = split_o ? len_w - room : '0;
    addr2_o = {addr_i[WA_W-1:PAGE_W] + 1'b1, {PAGE_W{1'b0}}};
  end
endmodule

// File: rtl/qbr_ctrl.sv
module qbr_ctrl
  import qbr_pkg::*;
#(
  parameter int WA_W     = 22,
  parameter int LEN_W    = 11,
  parameter int PAGE_W   = 10,
  parameter int WAIT_CLK = 6,
  parameter int GAP_CYC  = 6,
  localparam int CW      = (LEN_W > PAGE_W ? LEN_W : PAGE_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [WA_W-1:0]  req_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             split_i,
  input  logic [CW-1:0]    len1_i,
  input  logic [CW-1:0]    len2_i,
  input  logic [WA_W-1:0]  addr2_i,
  output logic             start_o,
  output logic             done_o,
  output logic             nib_vld_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic [3:0]       io_o,
  output logic             io_oe_o
);
  localparam int PMAX = HDR_NIB + WAIT_CLK + 8 * (1 << PAGE_W);
  localparam int PW   = $clog2(PMAX + 1);
  localparam int GW   = $clog2(GAP_CYC + 1);
  localparam logic [PW-1:0] P_HDR = PW'(HDR_NIB);
  localparam logic [PW-1:0] P_DAT = PW'(HDR_NIB + WAIT_CLK);
  localparam logic [GW-1:0] G_END = GW'(GAP_CYC - 1);

  qbr_st_e         st;
  logic [PW-1:0]   pcnt, ptot, p_next;
  logic [GW-1:0]   gcnt;
  logic [31:0]     sr;
  logic            pend, cs_n_q, sclk_q, oe_q, done_q;
  logic [CW-1:0]   len2_q;
  logic [WA_W-1:0] addr2_q;
  logic            accept, gap_end, launch;
  logic [WA_W-1:0] l_addr;
  logic [CW-1:0]   l_len;

  always_comb begin
    p_next  = pcnt + PW'(1);
    accept  = (st == ST_IDLE) && req_valid_i && (req_len_i != '0);
    gap_end = (st == ST_GAP) && (gcnt == G_END);
    launch  = accept || (gap_end && pend);
    l_addr  = (st == ST_IDLE) ? req_addr_i : addr2_q;
    l_len   = (st == ST_IDLE) ? len1_i : len2_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; cs_n_q <= 1'b1; sclk_q <= 1'b0; oe_q <= 1'b0; done_q <= 1'b0;
      sr <= '0; pcnt <= '0; ptot <= '0; gcnt <= '0; pend <= 1'b0;
      len2_q <= '0; addr2_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        pend    <= split_i;
        len2_q  <= len2_i;
        addr2_q <= addr2_i;
      end
      if (launch) begin
        if (!accept) pend <= 1'b0;
        st     <= ST_BUS;
        cs_n_q <= 1'b0;
        sclk_q <= 1'b0;
        oe_q   <= 1'b1;
        sr     <= {QREAD_OP, 24'({l_addr, 2'b00})};
        pcnt   <= '0;
        ptot   <= P_DAT + (PW'(l_len) << 3);
      end else begin
        case (st)
          ST_BUS: begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              pcnt   <= p_next;
              if (p_next < P_HDR)  sr   <= sr << 4;
              if (p_next == P_HDR) oe_q <= 1'b0;
              if (p_next == ptot) begin
                cs_n_q <= 1'b1;
                st     <= ST_GAP;
                gcnt   <= '0;
              end
            end
          end
          ST_GAP: begin
            if (gap_end) begin
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              gcnt <= gcnt + GW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign start_o   = accept;
  assign done_o    = done_q;
  assign nib_vld_o = (st == ST_BUS) && sclk_q && (p_next > P_DAT);
  assign cs_n_o    = cs_n_q;
  assign sclk_o    = sclk_q;
  assign io_o      = sr[31:28];
  assign io_oe_o   = oe_q;

  // chip-select-high run length, watched against the gap minimum
  logic [GW-1:0] hi_cnt;
  logic          seen_tx;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0; seen_tx <= 1'b0;
    end else if (!cs_n_q) begin
      hi_cnt <= '0; seen_tx <= 1'b1;
    end else if (hi_cnt != GW'(GAP_CYC)) begin
      hi_cnt <= hi_cnt + GW'(1);
    end
  end

  assert_cs_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_tx && $fell(cs_n_q)) |-> (hi_cnt >= GW'(GAP_CYC)));
  assert_sclk_parked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_q |-> !sclk_q);
  assert_bus_released_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_BUS && pcnt >= P_HDR) |-> !oe_q);
  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_IDLE && req_valid_i) |=> ($stable(len2_q) && $stable(addr2_q)));
  assert_done_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (cs_n_q && !pend));
endmodule

// File: rtl/qbr_assemble.sv
module qbr_assemble #(
  parameter int IDX_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             nib_vld_i,
  input  logic [3:0]       nib_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [31:0]      wr_data_o
);
  logic [2:0]       nc;
  logic [31:0]      acc, acc_n;
  logic [IDX_W-1:0] widx;
  logic [4:0]       pos;

  always_comb begin
    pos        = {nc[2:1], 3'b000} + (nc[0] ? 5'd0 : 5'd4);
    acc_n      = acc;
    acc_n[pos +: 4] = nib_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nc <= '0; acc <= '0; widx <= '0;
      wr_en_o <= 1'b0; wr_idx_o <= '0; wr_data_o <= '0;
    end else if (clr_i) begin
      nc <= '0; widx <= '0; wr_en_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (nib_vld_i) begin
        acc <= acc_n;
        nc  <= nc + 3'd1;
        if (nc == 3'd7) begin
          wr_en_o   <= 1'b1;
          wr_data_o <= acc_n;
          wr_idx_o  <= widx;
          widx      <= widx + IDX_W'(1);
        end
      end
    end
  end

  assert_word_spacing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
endmodule

// File: rtl/qspi_burst_reader.sv
module qspi_burst_reader #(
  parameter int WA_W     = 22,
  parameter int LEN_W    = 11,
  parameter int PAGE_W   = 10,
  parameter int WAIT_CLK = 6,
  parameter int GAP_CYC  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [WA_W-1:0]  req_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             done_o,
  output logic             wr_en_o,
  output logic [LEN_W-1:0] wr_idx_o,
  output logic [31:0]      wr_data_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic [3:0]       io_o,
  output logic             io_oe_o,
  input  logic [3:0]       io_i
);
  localparam int CW = (LEN_W > PAGE_W ? LEN_W : PAGE_W) + 1;

  logic            split, start, nib_vld;
  logic [CW-1:0]   len1, len2;
  logic [WA_W-1:0] addr2;

  qbr_split #(.WA_W(WA_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W)) u_split (
    .addr_i (req_addr_i), .len_i (req_len_i),
    .split_o(split), .len1_o(len1), .len2_o(len2), .addr2_o(addr2)
  );

  qbr_ctrl #(.WA_W(WA_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W),
             .WAIT_CLK(WAIT_CLK), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_len_i,
    .split_i(split), .len1_i(len1), .len2_i(len2), .addr2_i(addr2),
    .start_o(start), .done_o, .nib_vld_o(nib_vld),
    .cs_n_o, .sclk_o, .io_o, .io_oe_o
  );

  qbr_assemble #(.IDX_W(LEN_W)) u_asm (
    .clk_i, .rst_ni, .clr_i(start), .nib_vld_i(nib_vld), .nib_i(io_i),
    .wr_en_o, .wr_idx_o, .wr_data_o
  );
endmodule

// File: tb/sim_qspi_burst_reader.sv
module sim_qspi_burst_reader;
  localparam int CLK_PERIOD = 10;
  localparam int WA_W = 22, LEN_W = 5, PAGE_W = 4, WAIT_CLK = 4, GAP_CYC = 6;
  localparam int PAGE = 1 << PAGE_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [WA_W-1:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic done, wr_en, cs_n, sclk, io_oe;
  logic [LEN_W-1:0] wr_idx;
  logic [31:0] wr_data;
  logic [3:0] io_o, io_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qspi_burst_reader #(.WA_W(WA_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W),
    .WAIT_CLK(WAIT_CLK), .GAP_CYC(GAP_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_len_i(req_len), .done_o(done), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .cs_n_o(cs_n), .sclk_o(sclk), .io_o(io_o),
    .io_oe_o(io_oe), .io_i(io_i));

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input int b);
    return 8'((b * 29 + 7) ^ (b >> 8));
  endfunction

  function automatic logic [31:0] exp_word(input int wa);
    return {mem_byte(4*wa+3), mem_byte(4*wa+2), mem_byte(4*wa+1), mem_byte(4*wa)};
  endfunction

  // behavioural memory and pin monitor
  logic prev_cs_n = 1, prev_sclk = 0, seen = 0;
  int k = 0, hi_run = 0, min_gap = 1000, park_err = 0, oe_err = 0;
  logic [31:0] hdr_sh = '0;
  int tx_n = 0;
  int tx_cmd[4], tx_addr[4], tx_pulses[4];
  logic [31:0] got[32];
  int got_n = 0, done_n = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cs_n && sclk) park_err++;
      if (prev_cs_n && !cs_n) begin
        k = 0; hdr_sh = '0;
        if (seen && hi_run < min_gap) min_gap = hi_run;
        seen = 1;
      end
      if (!cs_n) begin
        if (sclk && !prev_sclk) begin
          k++;
          if (k <= 8) begin
            if (!io_oe) oe_err++;
            hdr_sh = {hdr_sh[27:0], io_o};
          end else if (io_oe) oe_err++;
        end
        if (!sclk && prev_sclk && k >= 8 + WAIT_CLK) begin
          automatic int j = k - 8 - WAIT_CLK;
          automatic logic [7:0] b = mem_byte(int'(hdr_sh[23:0]) + j/2);
          io_i = (j % 2 == 0) ? b[7:4] : b[3:0];
        end
      end
      if (!prev_cs_n && cs_n) begin
        if (tx_n < 4) begin
          tx_cmd[tx_n] = int'(hdr_sh[31:24]);
          tx_addr[tx_n] = int'(hdr_sh[23:0]);
          tx_pulses[tx_n] = k;
        end
        tx_n++;
        hi_run = 1;
      end else if (cs_n) hi_run++;
      if (wr_en) begin
        got[wr_idx] = wr_data;
        got_n++;
      end
      if (done) done_n++;
    end
    prev_cs_n = cs_n;
    prev_sclk = sclk;
  end

  task automatic issue(input int a, input int l);
    @(negedge clk);
    tx_n = 0; got_n = 0; done_n = 0;
    req_valid = 1; req_addr = WA_W'(a); req_len = LEN_W'(l);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic run_req(input int a, input int l);
    bit ok;
    int off, room, l1, mism, first_bad;
    issue(a, l);
    wait_done(ok);
    chk(ok, "R7 done reached", ok, 1);
    if (!ok) return;
    @(negedge clk);
    chk(!done && done_n == 1, "R7 done single pulse", done_n, 1);
    off = a % PAGE; room = PAGE - off;
    l1 = (l > room) ? room : l;
    chk(tx_n == ((l > room) ? 2 : 1), "R6 transaction count", tx_n, (l > room) ? 2 : 1);
    chk(tx_cmd[0] == 'hEB && tx_addr[0] == 4*a, "R1 opcode/address",
        {tx_cmd[0][7:0], tx_addr[0][23:0]}, {8'hEB, 24'(4*a)});
    chk(tx_pulses[0] == 8 + WAIT_CLK + 8*l1, "R4 pulse count first", tx_pulses[0], 8 + WAIT_CLK + 8*l1);
    if (l > room && tx_n == 2) begin
      chk(tx_cmd[1] == 'hEB && tx_addr[1] == 4*((a/PAGE + 1)*PAGE), "R7 second address",
          tx_addr[1], 4*((a/PAGE + 1)*PAGE));
      chk(tx_pulses[1] == 8 + WAIT_CLK + 8*(l - room), "R4 pulse count second",
          tx_pulses[1], 8 + WAIT_CLK + 8*(l - room));
    end
    chk(got_n == l, "R5 word count", got_n, l);
    mism = 0; first_bad = -1;
    for (int i = 0; i < l && i < 32; i++)
      if (got[i] !== exp_word(a + i)) begin mism++; if (first_bad < 0) first_bad = i; end
    if (first_bad < 0) chk(1, "R5 data", 0, 0);
    else chk(0, "R5 R2 data word", got[first_bad], exp_word(a + first_bad));
  endtask

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cs_n && !sclk && !io_oe && !done && !wr_en, "R11 reset outputs",
        {cs_n, sclk, io_oe, done, wr_en}, 5'b10000);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int off = 0; off < PAGE; off++) begin
      automatic int a = 'h120 + off;
      automatic int room = PAGE - off;
      run_req(a, 1);
      run_req(a, room);
      if (room + 1 <= PAGE) run_req(a, room + 1);
      run_req(a, PAGE);
    end

    chk(min_gap >= GAP_CYC, "R8 min chip-select gap", min_gap, GAP_CYC);
    chk(park_err == 0, "R9 clock high while deselected", park_err, 0);
    chk(oe_err == 0, "R3 output enable timing", oe_err, 0);

    // R10 request while busy is ignored
    issue(3, 2);
    repeat (5) @(negedge clk);
    req_valid = 1; req_addr = WA_W'(40); req_len = LEN_W'(3);
    @(negedge clk);
    req_valid = 0;
    wait_done(ok);
    repeat (30) @(negedge clk);
    chk(ok && tx_n == 1 && tx_addr[0] == 12, "R10 busy request ignored (tx)", tx_n, 1);
    chk(got_n == 2 && done_n == 1, "R10 busy request ignored (words)", got_n, 2);

    // R10 zero length ignored
    issue(5, 0);
    repeat (60) @(negedge clk);
    chk(tx_n == 0 && done_n == 0 && cs_n, "R10 zero length ignored", tx_n, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule